// File: doc/BRIEF.md
# Fused Immediate-Operand ALU Unit

This unit runs the immediate-mode combined operations of an 8-bit accumulator processor. Each of these opcodes merges two ALU actions into one step. They are an AND followed by a shift or a rotate, an AND that also sets carry from the sign bit, an AND of A with X followed by a compare-style subtract into X, a binary subtract with borrow, and two "merge" forms. In the merge forms, A is first ORed with a configurable constant and then ANDed with the other competing sources.

The unit takes these inputs:

- the opcode byte
- the immediate operand
- the current A and X values
- the incoming N, V, Z and C flags
- a valid strobe that qualifies all of the inputs

One clock after the strobe, it presents the complete next state: A, X and the four flags, each paired with a write-enable. Any register or flag that an opcode does not write passes through with its incoming value, and its enable stays low. The registered result is held until the next strobe. Bus sequencing, operand fetch and decimal arithmetic belong to the surrounding core.

Top module: `fused_imm_alu`

## Requirements
- R1: Opcode 0x4B forms t = A AND operand and writes t shifted right by one into A. A zero enters bit 7, and bit 0 of t goes to C.
- R2: Opcodes 0x0B and 0x2B both write A AND operand into A and copy bit 7 of that result into C.
- R3: Opcode 0x6B forms t = A AND operand and writes {C_in, t[7:1]} into A. C receives t[7]. V is the two's-complement overflow of the 8-bit sum t + operand.
- R4: Opcode 0xCB writes (A AND X) − operand, modulo 256, into X. C is 1 exactly when (A AND X) ≥ operand. V and A are not written.
- R5: Opcode 0x8B writes (A OR MAGIC) AND X AND operand into A, where MAGIC is a parameter (default 0xEE). C and V are not written.
- R6: Opcode 0xAB writes (A OR MAGIC) AND operand into both A and X.
- R7: Opcode 0xEB writes A − operand − (1 − C_in), modulo 256, into A. C is 1 when no borrow occurs. V is the two's-complement overflow of that subtraction.
- R8: For every recognised opcode, N is bit 7 and Z is (value == 0) of the value written. That value is X for 0xCB and A for all others.
- R9: The enables, listed as {A, X, N, V, Z, C}, are: 0x4B/0x0B/0x2B 101011; 0x6B/0xEB 101111; 0xCB 011011; 0x8B 101010; 0xAB 111010; any other opcode 000000. An output whose enable is low carries its input value.
- R10: The result appears on the outputs at the first rising edge after in_valid is sampled high. It stays unchanged on every edge where in_valid is low.
- R11: A synchronous active-high reset clears every data, flag and enable output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the opcode, operand and register inputs for one edge |
| opcode | input | 8 | Opcode byte |
| operand | input | 8 | Immediate operand |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current X register |
| n_in | input | 1 | Current negative flag |
| v_in | input | 1 | Current overflow flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| a_out | output | 8 | Next accumulator |
| x_out | output | 8 | Next X register |
| n_out | output | 1 | Next negative flag |
| v_out | output | 1 | Next overflow flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| we_a | output | 1 | Accumulator write-enable |
| we_x | output | 1 | X write-enable |
| we_n | output | 1 | N write-enable |
| we_v | output | 1 | V write-enable |
| we_z | output | 1 | Z write-enable |
| we_c | output | 1 | C write-enable |

## Verification
The bench drives the rotate form with both carry-in values and with operands that do and do not overflow the sum. A unit that fed carry from bit 0, or that left V alone, would show the wrong C or V there.

The subtract forms are checked at the equal-operand boundary and on wrap-around. A unit with inverted borrow sense would flip C at exactly those points, and the X-destination form would leave N and Z taken from A.

The merge forms run with A = 0, so that only the constant survives the OR. A design that dropped the constant would return zero.

An unlisted opcode, a run of idle cycles with changing inputs, and a reset in the middle of a run each check that nothing is written, that results are held, and that all outputs clear.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;

    localparam int DATA_W = 8;
    localparam int MSB    = DATA_W - 1;

    typedef logic [DATA_W-1:0] word_t;

    localparam logic [7:0] OPC_ALR   = 8'h4B;
    localparam logic [7:0] OPC_ANC_0 = 8'h0B;
    localparam logic [7:0] OPC_ANC_1 = 8'h2B;
    localparam logic [7:0] OPC_ARR   = 8'h6B;
    localparam logic [7:0] OPC_SBX   = 8'hCB;
    localparam logic [7:0] OPC_ANE   = 8'h8B;
    localparam logic [7:0] OPC_LXA   = 8'hAB;
    localparam logic [7:0] OPC_SBC   = 8'hEB;

    typedef enum logic [2:0] {
        K_NONE, K_ANDSHR, K_ANDSGN, K_ANDROR, K_AXSUB, K_MRGX, K_MRGAX, K_SUBB
    } kind_e;

    typedef struct packed {
        logic a;
        logic x;
        logic n;
        logic v;
        logic z;
        logic c;
    } wen_t;

    typedef struct packed {
        word_t a;
        word_t x;
        logic  n;
        logic  v;
        logic  z;
        logic  c;
        wen_t  we;
    } state_t;

    function automatic kind_e classify(input logic [7:0] opc);
        kind_e k;
        case (opc)
            OPC_ALR:              k = K_ANDSHR;
            OPC_ANC_0, OPC_ANC_1: k = K_ANDSGN;
            OPC_ARR:              k = K_ANDROR;
            OPC_SBX:              k = K_AXSUB;
            OPC_ANE:              k = K_MRGX;
            OPC_LXA:              k = K_MRGAX;
            OPC_SBC:              k = K_SUBB;
            default:              k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic wen_t enables(input kind_e k);
        wen_t w;
        case (k)
            K_ANDSHR, K_ANDSGN: w = '{a:1'b1, x:1'b0, n:1'b1, v:1'b0, z:1'b1, c:1'b1};
            K_ANDROR, K_SUBB:   w = '{a:1'b1, x:1'b0, n:1'b1, v:1'b1, z:1'b1, c:1'b1};
            K_AXSUB:            w = '{a:1'b0, x:1'b1, n:1'b1, v:1'b0, z:1'b1, c:1'b1};
            K_MRGX:             w = '{a:1'b1, x:1'b0, n:1'b1, v:1'b0, z:1'b1, c:1'b0};
            K_MRGAX:            w = '{a:1'b1, x:1'b1, n:1'b1, v:1'b0, z:1'b1, c:1'b0};
            default:            w = '0;
        endcase
        return w;
    endfunction

    function automatic logic is_zero(input word_t w);
        return (w == '0);
    endfunction

endpackage

// File: rtl/fused_merge.sv
module fused_merge
    import fused_alu_pkg::*;
#(
    parameter word_t MAGIC = 8'hEE
) (
    input  word_t a,
    input  word_t x,
    input  word_t op,
    output word_t and_aop,
    output word_t and_ax,
    output word_t mrg_x,
    output word_t mrg_ax
);
    word_t leaky_a;

    always_comb begin
        leaky_a = a | MAGIC;
        and_aop = a & op;
        and_ax  = a & x;
        mrg_x   = leaky_a & x & op;
        mrg_ax  = leaky_a & op;
    end
endmodule

// File: rtl/fused_shift.sv
module fused_shift
    import fused_alu_pkg::*;
(
    input  word_t t,
    input  word_t op,
    input  logic  cin,
    output word_t shr_res,
    output logic  shr_c,
    output word_t ror_res,
    output logic  ror_c,
    output logic  ror_v
);
    word_t sum;

    always_comb begin
        shr_res = {1'b0, t[MSB:1]};
        shr_c   = t[0];
        ror_res = {cin, t[MSB:1]};
        ror_c   = t[MSB];
        sum     = t + op;
        ror_v   = (t[MSB] == op[MSB]) && (sum[MSB] != t[MSB]);
    end
endmodule

// File: rtl/fused_sub.sv
module fused_sub
    import fused_alu_pkg::*;
(
    input  word_t lhs,
    input  word_t rhs,
    input  logic  carry_in,
    output word_t diff,
    output logic  carry_out,
    output logic  ovf
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide      = {1'b0, lhs} + {1'b0, ~rhs} + {{DATA_W{1'b0}}, carry_in};
        diff      = wide[DATA_W-1:0];
        carry_out = wide[DATA_W];
        ovf       = (lhs[MSB] ^ rhs[MSB]) & (lhs[MSB] ^ diff[MSB]);
    end
endmodule

// File: rtl/fused_imm_alu.sv
module fused_imm_alu
    import fused_alu_pkg::*;
#(
    parameter word_t MAGIC = 8'hEE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] opcode,
    input  logic [7:0] operand,
    input  logic [7:0] a_in,
    input  logic [7:0] x_in,
    input  logic       n_in,
    input  logic       v_in,
    input  logic       z_in,
    input  logic       c_in,
    output logic [7:0] a_out,
    output logic [7:0] x_out,
    output logic       n_out,
    output logic       v_out,
    output logic       z_out,
    output logic       c_out,
    output logic       we_a,
    output logic       we_x,
    output logic       we_n,
    output logic       we_v,
    output logic       we_z,
    output logic       we_c
);
    kind_e  kind;
    word_t  and_aop, and_ax, mrg_x, mrg_ax;
    word_t  shr_res, ror_res, sub_diff, sub_lhs;
    logic   shr_c, ror_c, ror_v, sub_c, sub_v, sub_cin;
    state_t nxt, cur;

    assign kind = classify(opcode);

    fused_merge #(.MAGIC(MAGIC)) u_merge (
        .a(a_in), .x(x_in), .op(operand),
        .and_aop(and_aop), .and_ax(and_ax), .mrg_x(mrg_x), .mrg_ax(mrg_ax)
    );

    fused_shift u_shift (
        .t(and_aop), .op(operand), .cin(c_in),
        .shr_res(shr_res), .shr_c(shr_c),
        .ror_res(ror_res), .ror_c(ror_c), .ror_v(ror_v)
    );

    // One subtracter serves both the compare-into-X form and subtract-with-borrow.
    assign sub_lhs = (kind == K_AXSUB) ? and_ax : a_in;
    assign sub_cin = (kind == K_AXSUB) ? 1'b1 : c_in;

    fused_sub u_sub (
        .lhs(sub_lhs), .rhs(operand), .carry_in(sub_cin),
        .diff(sub_diff), .carry_out(sub_c), .ovf(sub_v)
    );

    always_comb begin
        nxt.a  = a_in;
        nxt.x  = x_in;
        nxt.n  = n_in;
        nxt.v  = v_in;
        nxt.z  = z_in;
        nxt.c  = c_in;
        nxt.we = enables(kind);
        case (kind)
            K_ANDSHR: begin nxt.a = shr_res; nxt.c = shr_c; end
            K_ANDSGN: begin nxt.a = and_aop; nxt.c = and_aop[MSB]; end
            K_ANDROR: begin nxt.a = ror_res; nxt.c = ror_c; nxt.v = ror_v; end
            K_AXSUB:  begin nxt.x = sub_diff; nxt.c = sub_c; end
            K_MRGX:   begin nxt.a = mrg_x; end
            K_MRGAX:  begin nxt.a = mrg_ax; nxt.x = mrg_ax; end
            K_SUBB:   begin nxt.a = sub_diff; nxt.c = sub_c; nxt.v = sub_v; end
            default:  ;
        endcase
        if (kind == K_AXSUB) begin
            nxt.n = nxt.x[MSB];
            nxt.z = is_zero(nxt.x);
        end else if (kind != K_NONE) begin
            nxt.n = nxt.a[MSB];
            nxt.z = is_zero(nxt.a);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (in_valid)
            cur <= nxt;
    end

    assign a_out = cur.a;
    assign x_out = cur.x;
    assign n_out = cur.n;
    assign v_out = cur.v;
    assign z_out = cur.z;
    assign c_out = cur.c;
    assign we_a  = cur.we.a;
    assign we_x  = cur.we.x;
    assign we_n  = cur.we.n;
    assign we_v  = cur.we.v;
    assign we_z  = cur.we.z;
    assign we_c  = cur.we.c;
endmodule

// File: rtl/fused_imm_alu_chk.sv
module fused_imm_alu_chk
    import fused_alu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] opcode,
    input logic [7:0] operand,
    input logic [7:0] a_in,
    input logic [7:0] a_out,
    input logic [7:0] x_out,
    input logic       n_out,
    input logic       v_out,
    input logic       z_out,
    input logic       c_out,
    input logic       we_a,
    input logic       we_x,
    input logic       we_n,
    input logic       we_v,
    input logic       we_z,
    input logic       we_c
);
    logic listed;
    assign listed = (opcode == OPC_ALR) || (opcode == OPC_ANC_0) || (opcode == OPC_ANC_1) ||
                    (opcode == OPC_ARR) || (opcode == OPC_SBX) || (opcode == OPC_ANE) ||
                    (opcode == OPC_LXA) || (opcode == OPC_SBC);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (a_out == 8'h00 && x_out == 8'h00 && {n_out, v_out, z_out, c_out} == 4'b0 &&
                 {we_a, we_x, we_n, we_v, we_z, we_c} == 6'b0)); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(a_out) && $stable(x_out) && $stable(n_out) && $stable(v_out) &&
                       $stable(z_out) && $stable(c_out) && $stable(we_a) && $stable(we_x))); // R10

    AST_NZ_FROM_A: assert property (@(posedge clk) disable iff (rst)
        (we_a && !we_x) |-> (n_out == a_out[7] && z_out == (a_out == 8'h00))); // R8

    AST_NZ_FROM_X: assert property (@(posedge clk) disable iff (rst)
        we_x |-> (n_out == x_out[7] && z_out == (x_out == 8'h00))); // R8

    AST_SHR_RESULT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == OPC_ALR) |=>
            (a_out == (($past(a_in) & $past(operand)) >> 1) &&
             c_out == ($past(a_in[0]) & $past(operand[0])))); // R1

    AST_SIGN_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (opcode == OPC_ANC_0 || opcode == OPC_ANC_1)) |=>
            (we_c && c_out == a_out[7])); // R2

    AST_DUAL_DEST_EQUAL: assert property (@(posedge clk) disable iff (rst)
        (we_a && we_x) |-> (a_out == x_out)); // R6

    AST_UNLISTED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !listed) |=> ({we_a, we_x, we_n, we_v, we_z, we_c} == 6'b0)); // R9
endmodule

bind fused_imm_alu fused_imm_alu_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .operand(operand),
    .a_in(a_in), .a_out(a_out), .x_out(x_out), .n_out(n_out), .v_out(v_out),
    .z_out(z_out), .c_out(c_out), .we_a(we_a), .we_x(we_x), .we_n(we_n),
    .we_v(we_v), .we_z(we_z), .we_c(we_c)
);

// File: tb/fused_imm_alu_test.sv
module fused_imm_alu_test;
    localparam logic [7:0] MAGIC = 8'hEE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] opcode = 8'h00, operand = 8'h00, a_in = 8'h00, x_in = 8'h00;
    logic       n_in = 1'b0, v_in = 1'b0, z_in = 1'b0, c_in = 1'b0;
    logic [7:0] a_out, x_out;
    logic       n_out, v_out, z_out, c_out;
    logic       we_a, we_x, we_n, we_v, we_z, we_c;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [7:0] ea, ex;
    logic       en, ev, ez, ec;
    logic [5:0] ewe;

    always #10 clk = ~clk;

    fused_imm_alu #(.MAGIC(MAGIC)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .operand(operand),
        .a_in(a_in), .x_in(x_in), .n_in(n_in), .v_in(v_in), .z_in(z_in), .c_in(c_in),
        .a_out(a_out), .x_out(x_out), .n_out(n_out), .v_out(v_out), .z_out(z_out),
        .c_out(c_out), .we_a(we_a), .we_x(we_x), .we_n(we_n), .we_v(we_v),
        .we_z(we_z), .we_c(we_c)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "A", a_out, ea);
        chk(tag, "X", x_out, ex);
        chk(tag, "NVZC", {n_out, v_out, z_out, c_out}, {en, ev, ez, ec});
        chk(tag, "WE", {we_a, we_x, we_n, we_v, we_z, we_c}, ewe);
    endtask

    // Reference model built from the requirement text.
    task automatic model(input logic [7:0] opc, input logic [7:0] a, input logic [7:0] x,
                         input logic [7:0] op, input logic n, input logic v,
                         input logic z, input logic c);
        logic [7:0] t;
        int r;
        ea = a; ex = x; en = n; ev = v; ez = z; ec = c; ewe = 6'b000000;
        t = a & op;
        case (opc)
            8'h4B: begin ea = t >> 1; ec = t[0]; ewe = 6'b101011; end
            8'h0B, 8'h2B: begin ea = t; ec = t[7]; ewe = 6'b101011; end
            8'h6B: begin
                ea = {c, t[7:1]}; ec = t[7];
                r = int'(t) + int'(op);
                ev = (((t ^ r[7:0]) & (op ^ r[7:0]) & 8'h80) != 0);
                ewe = 6'b101111;
            end
            8'hCB: begin
                r = int'(a & x) - int'(op);
                ex = r[7:0]; ec = (int'(a & x) >= int'(op)); ewe = 6'b011011;
            end
            8'h8B: begin ea = (a | MAGIC) & x & op; ewe = 6'b101010; end
            8'hAB: begin ea = (a | MAGIC) & op; ex = ea; ewe = 6'b111010; end
            8'hEB: begin
                r = int'(a) - int'(op) - (c ? 0 : 1);
                ea = r[7:0]; ec = (r >= 0);
                ev = (((a ^ op) & (a ^ ea) & 8'h80) != 0);
                ewe = 6'b101111;
            end
            default: ;
        endcase
        if (opc == 8'hCB) begin en = ex[7]; ez = (ex == 8'h00); end
        else if (ewe != 6'b000000) begin en = ea[7]; ez = (ea == 8'h00); end
    endtask

    task automatic run_op(input string tag, input logic [7:0] opc, input logic [7:0] a,
                          input logic [7:0] x, input logic [7:0] op, input logic [3:0] nvzc);
        @(negedge clk);
        opcode = opc; a_in = a; x_in = x; operand = op;
        {n_in, v_in, z_in, c_in} = nvzc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(opc, a, x, op, nvzc[3], nvzc[2], nvzc[1], nvzc[0]);
        chk_all(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        ea = 0; ex = 0; {en, ev, ez, ec} = 4'b0; ewe = 6'b0;
        chk_all("R11 initial reset");
    endtask

    task automatic t_shr();
        run_op("R1 shr", 8'h4B, 8'hFF, 8'h00, 8'h81, 4'b0100); // V kept
        run_op("R1 shr zero", 8'h4B, 8'h01, 8'h00, 8'h01, 4'b0000);
    endtask

    task automatic t_sign();
        run_op("R2 anc 0B", 8'h0B, 8'hF0, 8'h00, 8'h80, 4'b0000);
        run_op("R2 anc 2B", 8'h2B, 8'h7F, 8'h00, 8'hFF, 4'b0001);
    endtask

    task automatic t_ror();
        run_op("R3 ror cin1", 8'h6B, 8'hFF, 8'h00, 8'h40, 4'b0001);
        run_op("R3 ror cin0", 8'h6B, 8'hC3, 8'h00, 8'h81, 4'b0100);
        run_op("R3 ror nov", 8'h6B, 8'h0F, 8'h00, 8'h05, 4'b0100);
    endtask

    task automatic t_axsub();
        run_op("R4 sbx equal", 8'hCB, 8'h3C, 8'h0F, 8'h0C, 4'b0100);
        run_op("R4 sbx wrap", 8'hCB, 8'hFF, 8'h01, 8'h02, 4'b0000);
        run_op("R8 sbx nz from X", 8'hCB, 8'h00, 8'hFF, 8'h00, 4'b1000);
    endtask

    task automatic t_merge();
        run_op("R5 ane magic", 8'h8B, 8'h00, 8'hFF, 8'hFF, 4'b0001);
        run_op("R5 ane zero", 8'h8B, 8'h11, 8'hFF, 8'hFF, 4'b0000);
        run_op("R6 lxa", 8'hAB, 8'h00, 8'h55, 8'hFF, 4'b0000);
        run_op("R6 lxa full", 8'hAB, 8'hFF, 8'h00, 8'h5A, 4'b0000);
    endtask

    task automatic t_subb();
        run_op("R7 sbc noborrow", 8'hEB, 8'h50, 8'h00, 8'h50, 4'b0001);
        run_op("R7 sbc borrow", 8'hEB, 8'h50, 8'h00, 8'h50, 4'b0000);
        run_op("R7 sbc ovf", 8'hEB, 8'h80, 8'h00, 8'h01, 4'b0001);
    endtask

    task automatic t_unlisted();
        run_op("R9 unlisted 4A", 8'h4A, 8'h12, 8'h34, 8'h56, 4'b1010);
        run_op("R9 unlisted E9", 8'hE9, 8'h77, 8'h01, 8'h01, 4'b0101);
    endtask

    task automatic t_hold();
        run_op("R10 setup", 8'hAB, 8'h00, 8'h00, 8'hF3, 4'b0000);
        @(negedge clk);
        opcode = 8'h4B; a_in = 8'hFF; operand = 8'hFF; x_in = 8'h99;
        {n_in, v_in, z_in, c_in} = 4'b1111;
        repeat (3) @(negedge clk);
        chk_all("R10 hold idle");
    endtask

    task automatic t_midreset();
        run_op("R11 setup", 8'hEB, 8'h10, 8'h20, 8'h01, 4'b1111);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ea = 0; ex = 0; {en, ev, ez, ec} = 4'b0; ewe = 6'b0;
        chk_all("R11 mid reset");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        rst = 1'b0;
        t_shr();
        t_sign();
        t_ror();
        t_axsub();
        t_merge();
        t_subb();
        t_unlisted();
        t_hold();
        t_midreset();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule